// File: doc/BRIEF.md
# Command-Pointer Register Slave for a Two-Wire Serial Bus

This block is the bus-facing front end of a small register-mapped peripheral on an I2C/SMBus segment. It cleans up the raw clock and data lines with a synchronizer and a run-length glitch filter, then recognises START, repeated START and STOP conditions. It compares a 7-bit slave address, whose two low bits come from strap inputs, and shifts bytes in and out. The open-drain data driver appears as a single output-enable: when that signal is high, the data line is pulled low.

The first byte after the address in a write transaction is a command byte. That byte loads a persistent pointer. Every further written byte is delivered to the register bank as a one-cycle write strobe with its data, at the index the pointer holds. Reads are done by setting the pointer, issuing a repeated START with the read bit, and clocking data bytes out. Before each byte it sends, the slave pulses a read strobe. The bank returns the selected register on `rd_data_i` in the following cycle. The pointer never advances by itself. The same register is returned byte after byte, and across transactions, until a new command byte arrives. Pointer values at or above the register count are accepted: writes through them do nothing and reads through them return zero.

Top module: `cmdptr_i2c_slave`

## Requirements
- R1: An address byte whose upper seven bits equal 1110 0 followed by `strap_i[1:0]` (bit 0 of the byte is read=1/write=0) is acknowledged: `sda_oe_o` is high during the ninth clock.
- R2: An address byte that does not match is not acknowledged, and the slave neither acknowledges nor strobes anything until the next START.
- R3: In a write transaction the first byte after the address loads the command pointer, and `reg_idx_o` shows its low bits afterwards.
- R4: Every later byte of a write transaction is acknowledged and produces exactly one `wr_stb_o` pulse with that byte on `wr_data_o`, at the pointer's index.
- R5: Before each transmitted byte the slave pulses `rd_stb_o` once, samples `rd_data_i` in the cycle after the pulse, and sends that byte MSB first (`sda_oe_o` high for a 0 bit).
- R6: The pointer does not auto-increment: consecutive bytes and later transactions reach the same register until a new command byte is written.
- R7: When the master does not acknowledge a transmitted byte, the slave releases the line and issues no further read strobe in that transaction.
- R8: A pointer value of 4 or more is acknowledged. Write bytes through it produce no `wr_stb_o`, and read bytes through it are 0x00 with no `rd_stb_o`.
- R9: A STOP at any point ends the transfer. A partly received byte is discarded, and the pointer keeps its value.
- R10: A repeated START during a transaction restarts the address phase. A read then uses the pointer written just before it.
- R11: A pulse on either line shorter than `FILT_CYC` clock cycles has no effect on the bytes received.
- R12: While `rst` is high, the output-enable and both strobes are low and the pointer is 0. After reset, reads return register 0.
- R13: `wr_stb_o` and `rd_stb_o` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| strap_i | input | 2 | Low two bits of the slave address |
| rd_data_i | input | 8 | Register bank data, valid the cycle after `rd_stb_o` |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| reg_idx_o | output | IDX_W | Register index from the command pointer |
| wr_data_o | output | 8 | Byte to write |
| wr_stb_o | output | 1 | One-cycle write strobe |
| rd_stb_o | output | 1 | One-cycle read strobe |

## Verification
The bench goes after an out-of-range pointer. A design that masked the pointer to two bits would write into a real register and return its contents instead of zero. It also aborts a data byte halfway with STOP; a design that flushed partial shift contents would emit a spurious write strobe. Multi-byte reads with a final NACK check that no extra read strobe is issued, which a design that ignored the master's acknowledge would emit. They also check that the same register is returned every time, where an auto-incrementing design would drift. Short pulses on both lines in the middle of a byte expose a filter that lets glitches through: such a design would miscount bits or see a false START.

// File: rtl/i2c_cmdptr_pkg.sv
package i2c_cmdptr_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int STRAP_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX_REQ,
    ST_TX_LOAD,
    ST_TX,
    ST_TX_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int FILT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // two-flop synchronizer, then the output only follows a level held FILT_CYC cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_CYC - 1)) begin
        line_o <= sync_q[1];
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  // data edges only count as bus conditions while the clock stays high
  assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/i2c_cmdptr_engine.sv
module i2c_cmdptr_engine
  import i2c_cmdptr_pkg::*;
#(
  parameter int NREG = 4,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b11100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic               sda_f,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic [IDX_W-1:0]   reg_idx_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_stb_o,
  output logic               rd_stb_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0]  BITS_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0]  BITS_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] NREG_B    = BYTE_W'(NREG);

  bus_state_e          state_q;
  rx_kind_e            kind_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BYTE_W-1:0]   rx_q;
  logic [BYTE_W-2:0]   tx_q;
  logic [BYTE_W-1:0]   ptr_q;
  logic                rw_q;
  logic                mack_q;
  logic                ptr_ok;
  logic                addr_hit;

  assign ptr_ok    = (ptr_q < NREG_B);
  assign addr_hit  = (rx_q[BYTE_W-1:1] == {ADDR_HI, strap_i});
  assign reg_idx_o = ptr_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    wr_stb_o <= 1'b0;
    rd_stb_o <= 1'b0;
    if (rst) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_ADDR;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_data_o <= '0;
    end else if (start_ev) begin
      state_q  <= ST_RX;
      kind_q   <= K_ADDR;
      cnt_q    <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_ev) begin
      state_q  <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise && cnt_q != BITS_FULL) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_f};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BITS_FULL) begin
            unique case (kind_q)
              K_ADDR: begin
                if (addr_hit) begin
                  rw_q     <= rx_q[0];
                  sda_oe_o <= 1'b1;
                  state_q  <= ST_RX_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              K_CMD: begin
                ptr_q    <= rx_q;
                sda_oe_o <= 1'b1;
                state_q  <= ST_RX_ACK;
              end
              default: begin
                if (ptr_ok) begin
                  wr_stb_o  <= 1'b1;
                  wr_data_o <= rx_q;
                end
                sda_oe_o <= 1'b1;
                state_q  <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            cnt_q    <= '0;
            if (kind_q == K_ADDR && rw_q) begin
              rd_stb_o <= ptr_ok;
              state_q  <= ST_TX_REQ;
            end else if (kind_q == K_ADDR) begin
              kind_q  <= K_CMD;
              state_q <= ST_RX;
            end else begin
              kind_q  <= K_DATA;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX_REQ: state_q <= ST_TX_LOAD;
        ST_TX_LOAD: begin
          tx_q     <= ptr_ok ? rd_data_i[BYTE_W-2:0] : '0;
          sda_oe_o <= ptr_ok ? ~rd_data_i[BYTE_W-1] : 1'b1;
          cnt_q    <= '0;
          state_q  <= ST_TX;
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == BITS_LAST) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_TX_ACK;
            end else begin
              sda_oe_o <= ~tx_q[BYTE_W-2];
              tx_q     <= {tx_q[BYTE_W-3:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              rd_stb_o <= ptr_ok;
              state_q  <= ST_TX_REQ;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdptr_i2c_slave.sv
module cmdptr_i2c_slave
  import i2c_cmdptr_pkg::*;
#(
  parameter int NREG = 4,
  parameter int FILT_CYC = 13,
  parameter logic [ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b11100,
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               sda_oe_o,
  output logic [IDX_W-1:0]   reg_idx_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               wr_stb_o,
  output logic               rd_stb_o
);
  logic [1:0] raw_w, filt_w;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filter #(.FILT_CYC(FILT_CYC)) i_filt (
      .clk    (clk),
      .rst    (rst),
      .line_i (raw_w[g]),
      .line_o (filt_w[g])
    );
  end

  assign scl_f = filt_w[0];
  assign sda_f = filt_w[1];

  i2c_bus_events i_events (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_cmdptr_engine #(
    .NREG    (NREG),
    .IDX_W   (IDX_W),
    .ADDR_HI (ADDR_HI)
  ) i_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_f     (sda_f),
    .strap_i   (strap_i),
    .rd_data_i (rd_data_i),
    .sda_oe_o  (sda_oe_o),
    .reg_idx_o (reg_idx_o),
    .wr_data_o (wr_data_o),
    .wr_stb_o  (wr_stb_o),
    .rd_stb_o  (rd_stb_o)
  );
endmodule

// File: rtl/cmdptr_i2c_slave_chk.sv
module cmdptr_i2c_slave_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_f,
  input logic             sda_oe,
  input logic             wr_stb,
  input logic             rd_stb,
  input logic [IDX_W-1:0] reg_idx
);
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb); // R13
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> !rd_stb); // R13
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && rd_stb)); // R13
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f); // R5
  AST_RD_IDX_HELD: assert property (@(posedge clk) disable iff (rst)
    rd_stb |-> $stable(reg_idx)); // R6
  AST_RST_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !wr_stb && !rd_stb && reg_idx == '0)); // R12
endmodule

bind cmdptr_i2c_slave cmdptr_i2c_slave_chk #(.IDX_W(IDX_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .scl_f   (scl_f),
  .sda_oe  (sda_oe_o),
  .wr_stb  (wr_stb_o),
  .rd_stb  (rd_stb_o),
  .reg_idx (reg_idx_o)
);

// File: tb/test_cmdptr_i2c_slave.sv
`timescale 1ns/1ps
module test_cmdptr_i2c_slave;
  localparam int HALF = 24;
  localparam int GL   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [7:0] rd_data = 8'h00;
  logic sda_oe, wr_stb, rd_stb;
  logic [1:0] reg_idx;
  logic [7:0] wr_data;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  cmdptr_i2c_slave i_cmdptr_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .rd_data_i(rd_data), .sda_oe_o(sda_oe), .reg_idx_o(reg_idx),
    .wr_data_o(wr_data), .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  // stand-in register bank: registered read data after a strobe
  logic [7:0] bank [4];
  logic [7:0] shadow [4];
  int wr_cnt = 0, rd_cnt = 0, ovl = 0;
  logic wr_prev = 1'b0, rd_prev = 1'b0;
  always @(posedge clk) begin
    if (wr_stb) begin bank[reg_idx] <= wr_data; wr_cnt++; end
    if (rd_stb) begin rd_data <= bank[reg_idx]; rd_cnt++; end
    if ((wr_stb && rd_stb) || (wr_stb && wr_prev) || (rd_stb && rd_prev)) ovl++;
    wr_prev <= wr_stb;
    rd_prev <= rd_stb;
  end

  int n_chk = 0, n_fail = 0;
  logic [7:0] cur_ptr = 8'h00;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [1:0] s, input bit rd);
    return {5'b11100, s, rd};
  endfunction

  function automatic logic [7:0] exp_val(input logic [7:0] p);
    return (p < 8'd4) ? shadow[p[1:0]] : 8'h00;
  endfunction

  function automatic logic [7:0] wbyte(input logic [7:0] d0, input int k);
    return d0 + 8'(k * 37);
  endfunction

  task automatic hp(); repeat (HALF) @(posedge clk); #1; endtask
  task automatic cyc(input int n); repeat (n) @(posedge clk); #1; endtask

  task automatic m_start();
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp(); hp();
  endtask

  task automatic m_bits(input logic [7:0] b, input int nb, input bit glitch);
    for (int i = 0; i < nb; i++) begin
      sda_m = b[7-i];
      if (glitch && i == 3) begin
        cyc(8); scl_m = 1'b1; cyc(GL); scl_m = 1'b0;
      end
      hp(); scl_m = 1'b1;
      if (glitch && i == 3) begin
        cyc(8); sda_m = ~sda_m; cyc(GL); sda_m = ~sda_m;
      end
      hp(); scl_m = 1'b0;
    end
  endtask

  task automatic m_send(input logic [7:0] b, input bit glitch, output bit acked);
    m_bits(b, 8, glitch);
    sda_m = 1'b1; hp(); scl_m = 1'b1;
    cyc(HALF / 2); acked = (sda_line == 1'b0);
    cyc(HALF - HALF / 2); scl_m = 1'b0;
  endtask

  task automatic m_recv(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hp(); scl_m = 1'b1; cyc(HALF / 2); b[7-i] = sda_line;
      cyc(HALF - HALF / 2); scl_m = 1'b0;
    end
    sda_m = ack ? 1'b0 : 1'b1;
    hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                          input bit glitch, input string req);
    bit a;
    int w0 = wr_cnt;
    m_start();
    m_send(addr_byte(strap, 1'b0), 1'b0, a); chk(a, "R1", a, 1);
    m_send(cmd, 1'b0, a); chk(a, req, a, 1);
    cur_ptr = cmd;
    for (int k = 0; k < n; k++) begin
      m_send(wbyte(d0, k), glitch, a); chk(a, "R4", a, 1);
    end
    m_stop();
    chk(reg_idx == cmd[1:0], "R3", reg_idx, cmd[1:0]);
    chk(wr_cnt - w0 == ((cmd < 8'd4) ? n : 0), req, wr_cnt - w0, (cmd < 8'd4) ? n : 0);
    if (cmd < 8'd4 && n > 0) shadow[cmd[1:0]] = wbyte(d0, n - 1);
  endtask

  task automatic do_read(input bit set_ptr, input logic [7:0] cmd, input int n, input string req);
    bit a;
    logic [7:0] b;
    int r0 = rd_cnt;
    m_start();
    if (set_ptr) begin
      m_send(addr_byte(strap, 1'b0), 1'b0, a); chk(a, "R1", a, 1);
      m_send(cmd, 1'b0, a); chk(a, "R3", a, 1);
      cur_ptr = cmd;
      m_start(); // repeated START, R10
    end
    m_send(addr_byte(strap, 1'b1), 1'b0, a); chk(a, "R10", a, 1);
    for (int k = 0; k < n; k++) begin
      m_recv(k != n - 1, b);
      chk(b == exp_val(cur_ptr), req, b, exp_val(cur_ptr));
    end
    m_stop();
    chk(rd_cnt - r0 == ((cur_ptr < 8'd4) ? n : 0), "R7", rd_cnt - r0, (cur_ptr < 8'd4) ? n : 0);
  endtask

  initial begin
    bit a;
    int w0;
    void'($urandom(32'd7349));
    for (int k = 0; k < 4; k++) begin
      bank[k] = 8'h40 + 8'(k * 17);
      shadow[k] = 8'h40 + 8'(k * 17);
    end
    cyc(10);
    // R12: state held in reset
    chk(sda_oe == 1'b0 && reg_idx == 2'd0 && !wr_stb && !rd_stb, "R12", {sda_oe, reg_idx}, 0);
    rst = 1'b0;
    cyc(20);
    do_read(1'b0, 8'h00, 1, "R12");                 // default pointer is register 0
    do_write(8'h01, 1, 8'hA5, 1'b0, "R4");
    do_read(1'b1, 8'h01, 1, "R5");
    do_write(8'h02, 3, 8'h19, 1'b0, "R4");
    do_read(1'b1, 8'h02, 3, "R6");                  // same register every byte
    do_read(1'b0, 8'h02, 2, "R6");                  // and in a new transaction
    do_read(1'b1, 8'h03, 1, "R6");                  // neighbour untouched
    // R8: out-of-range pointer
    do_write(8'h07, 2, 8'hEE, 1'b0, "R8");
    do_read(1'b0, 8'h07, 2, "R8");
    do_read(1'b1, 8'hC1, 1, "R8");
    // R2: address mismatch
    w0 = wr_cnt;
    m_start();
    m_send(addr_byte(2'b01, 1'b0), 1'b0, a); chk(!a, "R2", a, 0);
    m_send(8'h01, 1'b0, a); chk(!a, "R2", a, 0);
    m_send(8'h5C, 1'b0, a); chk(!a, "R2", a, 0);
    m_stop();
    chk(wr_cnt == w0, "R2", wr_cnt - w0, 0);
    chk(reg_idx == cur_ptr[1:0], "R2", reg_idx, cur_ptr[1:0]);
    // R1: other strap value
    strap = 2'b01;
    cyc(4);
    m_start();
    m_send(addr_byte(2'b10, 1'b0), 1'b0, a); chk(!a, "R1", a, 0);
    m_stop();
    do_write(8'h03, 1, 8'h6B, 1'b0, "R1");
    do_read(1'b1, 8'h03, 1, "R1");
    // R9: STOP in the middle of a data byte
    w0 = wr_cnt;
    m_start();
    m_send(addr_byte(strap, 1'b0), 1'b0, a);
    m_send(8'h01, 1'b0, a);
    cur_ptr = 8'h01;
    m_bits(8'hF0, 4, 1'b0);
    scl_m = 1'b0;
    m_stop();
    chk(wr_cnt == w0, "R9", wr_cnt - w0, 0);
    chk(reg_idx == 2'd1, "R9", reg_idx, 1);
    do_read(1'b0, 8'h01, 1, "R9");
    // R10: repeated START right after data bytes
    m_start();
    m_send(addr_byte(strap, 1'b0), 1'b0, a);
    m_send(8'h00, 1'b0, a);
    m_send(8'h3E, 1'b0, a); chk(a, "R10", a, 1);
    shadow[0] = 8'h3E; cur_ptr = 8'h00;
    begin
      logic [7:0] b;
      m_start();
      m_send(addr_byte(strap, 1'b1), 1'b0, a); chk(a, "R10", a, 1);
      m_recv(1'b0, b); chk(b == 8'h3E, "R10", b, 8'h3E);
      m_stop();
    end
    // R11: short pulses on both lines mid-byte
    do_write(8'h02, 1, 8'h3C, 1'b1, "R11");
    do_read(1'b1, 8'h02, 1, "R11");
    // R12: reset mid-run clears the pointer
    rst = 1'b1; cyc(5);
    chk(reg_idx == 2'd0 && !sda_oe, "R12", reg_idx, 0);
    rst = 1'b0; cyc(5);
    cur_ptr = 8'h00;
    do_read(1'b0, 8'h00, 1, "R12");
    // random mix
    for (int it = 0; it < 14; it++) begin
      logic [7:0] p;
      p = 8'($urandom_range(0, 5));
      do_write(p, $urandom_range(1, 3), 8'($urandom), 1'b0, "R4");
      do_read(1'($urandom_range(0, 1)), p, $urandom_range(1, 3), "R6");
    end
    chk(ovl == 0, "R13", ovl, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule